// File: doc/BRIEF.md
# Color channel sampling sequencer

This block picks which color channel (red, green or blue) a three-color imaging front end samples next. A host loads two 9-bit words through a small parallel write port: a configuration word at address 0 and a channel-select word at address 1. A per-pixel sample strobe and a line sync pulse then drive a one-hot channel select output.

In three-channel mode the select rotates through the colors on each sample strobe, either red-green-blue or blue-green-red. A sync pulse always returns it to the first color of the active order. In one-channel mode the select stays on a single color chosen by three select bits, whatever the strobes do. A power-down bit freezes the sequencer and keeps every stored setting. Writes that change the mode or the rotation order are staged and only take effect at the next sync pulse, so a line that has already started is never cut short.

Top module: `color_seq`

## Requirements
- R1: After reset, `chan_sel_o` is 3'b100 (red), `tri_mode_o` is 1 (three-channel mode, R-G-B order), `pwr_dn_o` is 0, and the stored one-channel select is red only.
- R2: `chan_sel_o` encodes red as bit 2, green as bit 1 and blue as bit 0. In three-channel mode with the order bit set, each sample strobe moves the select one color forward on the next clock edge: red to green, green to blue, blue back to red.
- R3: When the active order bit is clear, three-channel stepping runs blue to green, green to red, red back to blue.
- R4: A sync pulse in three-channel mode sets `chan_sel_o` to the first color of the active order on the next edge: red for R-G-B, blue for B-G-R. This holds even when a strobe arrives in the same cycle.
- R5: The mode bit (configuration bit 5, 1 = three-channel) and the order bit (select word bit 7, 1 = R-G-B) are staged when written. They become active only on a clock edge that samples a sync pulse. `tri_mode_o` shows the active mode.
- R6: In one-channel mode `chan_sel_o` follows the select bits (select word bit 6 red, bit 5 green, bit 4 blue) and does not change on strobes or syncs. A new select value shows at the output by the second clock edge after its write.
- R7: If several one-channel select bits are set, red wins over green and green wins over blue. With none set, `chan_sel_o` is 3'b000.
- R8: Configuration bit 2 set drives `pwr_dn_o` high from the next edge. While it is high, `chan_sel_o` holds and strobes and syncs are ignored. All written settings are kept, and operation resumes from them once the bit is cleared.
- R9: Writes to addresses other than 0 and 1 change nothing. Word bits other than those named above have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 3 | Write address (0 configuration, 1 channel select) |
| wr_data_i | input | 9 | Write data |
| smp_stb_i | input | 1 | Per-pixel sample strobe |
| sync_i | input | 1 | Line/pixel sync pulse |
| chan_sel_o | output | 3 | One-hot channel select {red, green, blue} |
| tri_mode_o | output | 1 | Active mode, 1 = three-channel |
| pwr_dn_o | output | 1 | Power-down flag |

## Verification
A corrupted channel register, or an off-by-one rotation, shows at `chan_sel_o` on the edge after the next strobe. It stays wrong until a sync repairs it, so comparing the output on every clock finds the fault within one pixel. A staging fault, where mode or order takes effect too early or never, appears either as a change in `tri_mode_o` or the rotation direction before the sync, or as an unchanged first color after it. A broken power-down gate shows as the select moving while `pwr_dn_o` is high.

// File: rtl/color_seq_pkg.sv
package color_seq_pkg;
  localparam int NCH = 3;
  typedef logic [NCH-1:0] chan_t;

  localparam chan_t CH_RED  = 3'b100;
  localparam chan_t CH_BLUE = 3'b001;

  // fwd: R->G->B ; rev: B->G->R
  function automatic chan_t chan_step(input chan_t cur, input logic fwd);
    return fwd ? {cur[0], cur[NCH-1:1]} : {cur[NCH-2:0], cur[NCH-1]};
  endfunction
endpackage

// File: rtl/seq_regs.sv
module seq_regs #(
  parameter int DATA_W    = 9,
  parameter int ADDR_W    = 3,
  parameter int CFG_ADDR  = 0,
  parameter int SEL_ADDR  = 1,
  parameter int MODE_BIT  = 5,
  parameter int PD_BIT    = 2,
  parameter int ORDER_BIT = 7,
  parameter int PICK_LSB  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  output logic                       sh_mode_o,
  output logic                       pd_o,
  output logic                       sh_order_o,
  output color_seq_pkg::chan_t       pick_o
);
  import color_seq_pkg::*;

  localparam logic [DATA_W-1:0] USED_MASK =
    DATA_W'((1 << MODE_BIT) | (1 << PD_BIT) | (1 << ORDER_BIT) | (((1 << NCH) - 1) << PICK_LSB));

  logic cfg_we, sel_we;
  logic unused_bits;

  assign cfg_we = wr_en_i && (wr_addr_i == ADDR_W'(CFG_ADDR));
  assign sel_we = wr_en_i && (wr_addr_i == ADDR_W'(SEL_ADDR));
  assign unused_bits = ^(wr_data_i & ~USED_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_mode_o  <= 1'b1;
      pd_o       <= 1'b0;
      sh_order_o <= 1'b1;
      pick_o     <= CH_RED;
    end else begin
      if (cfg_we) begin
        sh_mode_o <= wr_data_i[MODE_BIT];
        pd_o      <= wr_data_i[PD_BIT];
      end
      if (sel_we) begin
        sh_order_o <= wr_data_i[ORDER_BIT];
        pick_o     <= wr_data_i[PICK_LSB +: NCH];
      end
    end
  end
endmodule

// File: rtl/chan_prio.sv
module chan_prio #(
  parameter int N = 3
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  // highest index wins
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i == N-1) begin : g_top
      assign gnt_o[i] = req_i[i];
    end else begin : g_low
      assign gnt_o[i] = req_i[i] & ~|req_i[N-1:i+1];
    end
  end
endmodule

// File: rtl/seq_core.sv
module seq_core (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  stb_i,
  input  logic                  sync_i,
  input  logic                  pd_i,
  input  logic                  sh_mode_i,
  input  logic                  sh_order_i,
  input  color_seq_pkg::chan_t  pick_i,
  output color_seq_pkg::chan_t  chan_o,
  output logic                  act_mode_o,
  output logic                  act_order_o
);
  import color_seq_pkg::*;

  chan_t chan_n;
  logic  mode_n, order_n;

  always_comb begin
    mode_n  = act_mode_o;
    order_n = act_order_o;
    chan_n  = chan_o;
    if (!pd_i) begin
      if (sync_i) begin
        mode_n  = sh_mode_i;
        order_n = sh_order_i;
      end
      if (!mode_n)     chan_n = pick_i;
      else if (sync_i) chan_n = order_n ? CH_RED : CH_BLUE;
      else if (stb_i)  chan_n = chan_step(chan_o, order_n);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_o      <= CH_RED;
      act_mode_o  <= 1'b1;
      act_order_o <= 1'b1;
    end else begin
      chan_o      <= chan_n;
      act_mode_o  <= mode_n;
      act_order_o <= order_n;
    end
  end
endmodule

// File: rtl/color_seq.sv
module color_seq #(
  parameter int DATA_W   = 9,
  parameter int ADDR_W   = 3,
  parameter int CFG_ADDR = 0,
  parameter int SEL_ADDR = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              smp_stb_i,
  input  logic              sync_i,
  output logic [2:0]        chan_sel_o,
  output logic              tri_mode_o,
  output logic              pwr_dn_o
);
  import color_seq_pkg::*;

  logic  sh_mode, sh_order, act_order;
  chan_t pick_raw, pick;

  seq_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .SEL_ADDR(SEL_ADDR)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .sh_mode_o(sh_mode), .pd_o(pwr_dn_o), .sh_order_o(sh_order), .pick_o(pick_raw)
  );

  chan_prio #(.N(NCH)) u_prio (.req_i(pick_raw), .gnt_o(pick));

  seq_core u_core (
    .clk_i, .rst_ni,
    .stb_i(smp_stb_i), .sync_i, .pd_i(pwr_dn_o),
    .sh_mode_i(sh_mode), .sh_order_i(sh_order), .pick_i(pick),
    .chan_o(chan_sel_o), .act_mode_o(tri_mode_o), .act_order_o(act_order)
  );
endmodule

// File: rtl/color_seq_chk.sv
module color_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       smp_stb_i,
  input logic       sync_i,
  input logic [2:0] chan_sel_o,
  input logic       tri_mode_o,
  input logic       pwr_dn_o,
  input logic       act_order
);
  // R7: never more than one channel selected
  a_r7_onehot0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(chan_sel_o));

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tri_mode_o && !pwr_dn_o && smp_stb_i && !sync_i) |=>
      (chan_sel_o == ($past(act_order) ? {$past(chan_sel_o[0]), $past(chan_sel_o[2:1])}
                                       : {$past(chan_sel_o[1:0]), $past(chan_sel_o[2])})));

  a_r4_sync_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && !pwr_dn_o) |=> (!tri_mode_o || chan_sel_o == (act_order ? 3'b100 : 3'b001)));

  a_r6_onech_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tri_mode_o && !pwr_dn_o && !sync_i && !wr_en_i && !$past(wr_en_i)) |=> $stable(chan_sel_o));

  a_r8_pd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_o |=> ($stable(chan_sel_o) && $stable(tri_mode_o)));
endmodule

bind color_seq color_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .smp_stb_i(smp_stb_i),
  .sync_i(sync_i), .chan_sel_o(chan_sel_o), .tri_mode_o(tri_mode_o),
  .pwr_dn_o(pwr_dn_o), .act_order(act_order)
);

// File: tb/sim_color_seq.sv
`timescale 1ns/1ps
module sim_color_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [8:0] wr_data = '0;
  logic       stb = 1'b0;
  logic       sync = 1'b0;
  logic [2:0] chan;
  logic       tri_m, pd_o;

  int checks = 0;
  int fails = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  color_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .smp_stb_i(stb), .sync_i(sync),
    .chan_sel_o(chan), .tri_mode_o(tri_m), .pwr_dn_o(pd_o)
  );

  // reference model: color index 0 red, 1 green, 2 blue, -1 none
  int m_cur;
  bit m_sh_mode, m_sh_order, m_pd, m_act_mode, m_act_order;
  bit m_r, m_g, m_b;

  function automatic logic [2:0] idx2sel(input int i);
    case (i)
      0: return 3'b100;
      1: return 3'b010;
      2: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cur = 0; m_sh_mode = 1; m_sh_order = 1; m_pd = 0;
      m_act_mode = 1; m_act_order = 1; m_r = 1; m_g = 0; m_b = 0;
    end else begin
      if (!m_pd) begin
        if (sync) begin m_act_mode = m_sh_mode; m_act_order = m_sh_order; end
        if (!m_act_mode) m_cur = m_r ? 0 : m_g ? 1 : m_b ? 2 : -1;
        else if (sync) m_cur = m_act_order ? 0 : 2;
        else if (stb) m_cur = m_act_order ? (m_cur + 1) % 3 : (m_cur + 2) % 3;
      end
      if (wr_en && wr_addr == 3'd0) begin m_sh_mode = wr_data[5]; m_pd = wr_data[2]; end
      if (wr_en && wr_addr == 3'd1) begin
        m_sh_order = wr_data[7]; m_r = wr_data[6]; m_g = wr_data[5]; m_b = wr_data[4];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (chan !== idx2sel(m_cur) || tri_m !== m_act_mode || pd_o !== m_pd) begin
        fails++;
        $display("FAIL %s: chan/tri/pd actual %b/%b/%b expected %b/%b/%b",
                 tag, chan, tri_m, pd_o, idx2sel(m_cur), m_act_mode, m_pd);
      end
    end
  end

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {chan,tri,pd} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input bit we, input logic [2:0] a, input logic [8:0] d,
                     input bit s, input bit y);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; stb = s; sync = y;
  endtask

  task automatic wr(input logic [2:0] a, input logic [8:0] d);
    cyc(1, a, d, 0, 0);
  endtask
  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 1, 0);
  endtask
  task automatic syn();
    cyc(0, 0, 0, 0, 1);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  initial begin
    #40000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    tag = "R1"; chk("R1", {chan, tri_m, pd_o}, 5'b100_1_0);

    tag = "R2"; strobe(4); idle(1);
    chk("R2", {chan, tri_m, pd_o}, 5'b010_1_0);

    tag = "R4"; strobe(1);
    cyc(0, 0, 0, 1, 1); idle(1);
    chk("R4", {chan, tri_m, pd_o}, 5'b100_1_0);

    tag = "R5"; wr(3'd1, 9'h040); strobe(1); idle(1);
    chk("R5", {chan, tri_m, pd_o}, 5'b010_1_0);
    syn(); idle(1);
    chk("R5", {chan, tri_m, pd_o}, 5'b001_1_0);
    tag = "R3"; strobe(2); idle(1);
    chk("R3", {chan, tri_m, pd_o}, 5'b100_1_0);
    strobe(1); idle(1);
    chk("R3", {chan, tri_m, pd_o}, 5'b001_1_0);

    tag = "R5"; wr(3'd0, 9'h0D8); strobe(1); idle(1);
    chk("R5", {chan, tri_m, pd_o}, 5'b010_1_0);
    syn(); idle(1);
    chk("R5", {chan, tri_m, pd_o}, 5'b100_0_0);

    tag = "R6"; strobe(3); syn(); idle(1);
    chk("R6", {chan, tri_m, pd_o}, 5'b100_0_0);
    wr(3'd1, 9'h020); idle(2);
    chk("R6", {chan, tri_m, pd_o}, 5'b010_0_0);
    strobe(3); idle(1);
    chk("R6", {chan, tri_m, pd_o}, 5'b010_0_0);

    tag = "R7"; wr(3'd1, 9'h070); idle(2);
    chk("R7", {chan, tri_m, pd_o}, 5'b100_0_0);
    wr(3'd1, 9'h030); idle(2);
    chk("R7", {chan, tri_m, pd_o}, 5'b010_0_0);
    wr(3'd1, 9'h000); idle(2);
    chk("R7", {chan, tri_m, pd_o}, 5'b000_0_0);
    wr(3'd1, 9'h010); idle(2);
    chk("R7", {chan, tri_m, pd_o}, 5'b001_0_0);

    tag = "R8"; wr(3'd0, 9'h0DC); idle(1);
    chk("R8", {chan, tri_m, pd_o}, 5'b001_0_1);
    wr(3'd1, 9'h040); strobe(3); syn(); wr(3'd0, 9'h0FC); syn(); idle(2);
    chk("R8", {chan, tri_m, pd_o}, 5'b001_0_1);
    wr(3'd0, 9'h0F8); idle(2);
    chk("R8", {chan, tri_m, pd_o}, 5'b100_0_0);
    syn(); idle(1);
    chk("R8", {chan, tri_m, pd_o}, 5'b001_1_0);

    tag = "R9"; wr(3'd2, 9'h1FF); wr(3'd7, 9'h000); wr(3'd3, 9'h004); idle(1);
    chk("R9", {chan, tri_m, pd_o}, 5'b001_1_0);
    wr(3'd1, 9'h1CF); wr(3'd0, 9'h1FB); syn(); idle(1);
    chk("R9", {chan, tri_m, pd_o}, 5'b100_1_0);
    strobe(1); wr(3'd4, 9'h000); syn(); strobe(2); idle(1);
    chk("R9", {chan, tri_m, pd_o}, 5'b001_1_0);

    idle(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule